// File: doc/BRIEF.md
# Accumulator swap and extension unit

This unit performs one of six in-place transforms on a 32-bit accumulator held as two 16-bit halves, a high half and a low half. A caller presents a request carrying a three-bit operation code and the current contents of both halves. The unit accepts it, runs for a fixed number of cycles that depends on the operation, and then raises a one-cycle done pulse. In that cycle it presents the new halves, the values for the negative (N) and zero (Z) flags, and a write enable for each flag.

The request side follows valid/ready rules. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low for as long as the unit is busy, which includes the done cycle, so a caller must hold its request until ready returns. A request seen while ready is low is simply not taken. The result side has no back-pressure. The result fields hold their values from the cycle after acceptance until the next accepted request, but they are meaningful only while `done` is high. Flags whose enable is low must keep their old value in the caller's register.

Top module: `acc_xform_unit`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high and `req_op` is a legal code (0 to 5). `req_ready` equals the inverse of `busy`. After reset, `busy`, `done` and both flag enables are low and `req_ready` is high.
- R2: `done` rises in the Nth cycle after the accepting edge. N is 3 for byte swap (code 0), 2 for half exchange (code 1), 1 for byte sign extension (code 2), 2 for word sign extension (code 3), 1 for byte zero extension (code 4) and 1 for word zero extension (code 5).
- R3: `busy` is high in every cycle from the accepting edge through the done cycle and low in the cycle after. Each accepted request produces exactly one done pulse.
- R4: A request presented while busy is ignored. It changes neither the pending result nor the number of done pulses.
- R5: Byte swap (code 0) exchanges bits 7:0 and 15:8 of the low half, leaves the high half unchanged, and enables no flag write.
- R6: Half exchange (code 1) returns the old low half as the high half and the old high half as the low half, and enables no flag write.
- R7: Byte sign extension (code 2) fills bits 15:8 of the low half with bit 7 of the input low half and leaves the high half unchanged. It writes N as that bit and Z as whether the 16-bit low result is zero.
- R8: Word sign extension (code 3) fills the high half with bit 15 of the low half and leaves the low half unchanged. It writes N as that bit and Z as whether the whole 32-bit result is zero.
- R9: Byte zero extension (code 4) clears bits 15:8 of the low half and leaves the high half unchanged. It writes N as 0 and Z as whether the 16-bit low result is zero.
- R10: Word zero extension (code 5) clears the high half and leaves the low half unchanged. It writes N as 0 and Z as whether the 32-bit result is zero.
- R11: `wr_n` and `wr_z` are high only in a done cycle of an extension operation. In all other cycles they are low.
- R12: A request with code 6 or 7 is dropped. It does not make the unit busy and produces no done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_op | input | 3 | Operation code, 0 to 5 legal |
| req_hi | input | 16 | Current high half of the accumulator |
| req_lo | input | 16 | Current low half of the accumulator |
| busy | output | 1 | Operation in progress, done cycle included |
| done | output | 1 | One-cycle result strobe |
| res_hi | output | 16 | New high half |
| res_lo | output | 16 | New low half |
| res_n | output | 1 | New N flag value |
| res_z | output | 1 | New Z flag value |
| wr_n | output | 1 | Write enable for N |
| wr_z | output | 1 | Write enable for Z |

## Verification
The assertions check the rules that hold on every cycle:
- done only appears while busy, and busy drops in the cycle after it;
- busy never ends before done;
- the results stay stable while an operation runs;
- the flag enables appear only with done;
- a zero extension never writes N as 1;
- a legal accepted request always makes the unit busy.

The exact latency of each operation, the data and flag values of every transform, rejection of illegal codes, and ignoring of requests during busy can only be shown by the bench's directed scenarios. These use values chosen for sign and zero corner cases.

// File: rtl/acc_xform_pkg.sv
package acc_xform_pkg;
  typedef enum logic [2:0] {
    XOP_BSWAP = 3'd0,
    XOP_HXCHG = 3'd1,
    XOP_SEXTB = 3'd2,
    XOP_SEXTW = 3'd3,
    XOP_ZEXTB = 3'd4,
    XOP_ZEXTW = 3'd5
  } xop_e;

  function automatic logic xop_legal(input logic [2:0] code);
    return code <= 3'd5;
  endfunction
endpackage

// File: rtl/acc_xform_dp.sv
module acc_xform_dp
  import acc_xform_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic [2:0]        op,
  input  logic [HALF_W-1:0] hi_in,
  input  logic [HALF_W-1:0] lo_in,
  output logic [HALF_W-1:0] hi_out,
  output logic [HALF_W-1:0] lo_out,
  output logic              n_out,
  output logic              z_out,
  output logic              n_we,
  output logic              z_we
);
  localparam int BYTE_W = HALF_W / 2;

  logic [BYTE_W-1:0] lo_lsb, lo_msb;
  assign lo_lsb = lo_in[BYTE_W-1:0];
  assign lo_msb = lo_in[HALF_W-1:BYTE_W];

  always_comb begin
    hi_out = hi_in;
    lo_out = lo_in;
    n_out  = 1'b0;
    z_out  = 1'b0;
    n_we   = 1'b0;
    z_we   = 1'b0;
    case (xop_e'(op))
      XOP_BSWAP: lo_out = {lo_lsb, lo_msb};
      XOP_HXCHG: begin
        hi_out = lo_in;
        lo_out = hi_in;
      end
      XOP_SEXTB: begin
        lo_out = {{BYTE_W{lo_in[BYTE_W-1]}}, lo_lsb};
        n_out  = lo_in[BYTE_W-1];
        z_out  = (lo_lsb == '0);
        n_we   = 1'b1;
        z_we   = 1'b1;
      end
      XOP_SEXTW: begin
        hi_out = {HALF_W{lo_in[HALF_W-1]}};
        n_out  = lo_in[HALF_W-1];
        z_out  = (lo_in == '0);
        n_we   = 1'b1;
        z_we   = 1'b1;
      end
      XOP_ZEXTB: begin
        lo_out = {{BYTE_W{1'b0}}, lo_lsb};
        z_out  = (lo_lsb == '0);
        n_we   = 1'b1;
        z_we   = 1'b1;
      end
      XOP_ZEXTW: begin
        hi_out = '0;
        z_out  = (lo_in == '0);
        n_we   = 1'b1;
        z_we   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_xform_seq.sv
module acc_xform_seq
  import acc_xform_pkg::*;
#(
  parameter int LAT_BSWAP = 3,
  parameter int LAT_HXCHG = 2,
  parameter int LAT_SEXTB = 1,
  parameter int LAT_SEXTW = 2,
  parameter int LAT_ZEXTB = 1,
  parameter int LAT_ZEXTW = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] op,
  output logic       busy,
  output logic       done
);
  localparam int LAT_MAX = 8;
  localparam int CNT_W   = $clog2(LAT_MAX + 1);

  logic [CNT_W-1:0] remain, lat_sel;

  always_comb begin
    case (xop_e'(op))
      XOP_BSWAP: lat_sel = CNT_W'(LAT_BSWAP - 1);
      XOP_HXCHG: lat_sel = CNT_W'(LAT_HXCHG - 1);
      XOP_SEXTB: lat_sel = CNT_W'(LAT_SEXTB - 1);
      XOP_SEXTW: lat_sel = CNT_W'(LAT_SEXTW - 1);
      XOP_ZEXTB: lat_sel = CNT_W'(LAT_ZEXTB - 1);
      XOP_ZEXTW: lat_sel = CNT_W'(LAT_ZEXTW - 1);
      default:   lat_sel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        remain <= lat_sel;
      end
    end else if (remain == '0) begin
      busy <= 1'b0;
    end else begin
      remain <= remain - 1'b1;
    end
  end

  assign done = busy && (remain == '0);

  assert_done_ends_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  assert_busy_until_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

// File: rtl/acc_xform_unit.sv
module acc_xform_unit
  import acc_xform_pkg::*;
#(
  parameter int HALF_W    = 16,
  parameter int LAT_BSWAP = 3,
  parameter int LAT_HXCHG = 2,
  parameter int LAT_SEXTB = 1,
  parameter int LAT_SEXTW = 2,
  parameter int LAT_ZEXTB = 1,
  parameter int LAT_ZEXTW = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [HALF_W-1:0] req_hi,
  input  logic [HALF_W-1:0] req_lo,
  output logic              busy,
  output logic              done,
  output logic [HALF_W-1:0] res_hi,
  output logic [HALF_W-1:0] res_lo,
  output logic              res_n,
  output logic              res_z,
  output logic              wr_n,
  output logic              wr_z
);
  logic [HALF_W-1:0] c_hi, c_lo;
  logic c_n, c_z, c_nwe, c_zwe;
  logic nwe_q, zwe_q, zext_q, accept;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready && xop_legal(req_op);

  acc_xform_dp #(.HALF_W(HALF_W)) u_dp (
    .op(req_op), .hi_in(req_hi), .lo_in(req_lo),
    .hi_out(c_hi), .lo_out(c_lo), .n_out(c_n), .z_out(c_z),
    .n_we(c_nwe), .z_we(c_zwe)
  );

  acc_xform_seq #(
    .LAT_BSWAP(LAT_BSWAP), .LAT_HXCHG(LAT_HXCHG), .LAT_SEXTB(LAT_SEXTB),
    .LAT_SEXTW(LAT_SEXTW), .LAT_ZEXTB(LAT_ZEXTB), .LAT_ZEXTW(LAT_ZEXTW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .op(req_op),
    .busy(busy), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_hi <= '0;
      res_lo <= '0;
      res_n  <= 1'b0;
      res_z  <= 1'b0;
      nwe_q  <= 1'b0;
      zwe_q  <= 1'b0;
      zext_q <= 1'b0;
    end else if (accept) begin
      res_hi <= c_hi;
      res_lo <= c_lo;
      res_n  <= c_n;
      res_z  <= c_z;
      nwe_q  <= c_nwe;
      zwe_q  <= c_zwe;
      zext_q <= (req_op == XOP_ZEXTB) || (req_op == XOP_ZEXTW);
    end
  end

  assign wr_n = done && nwe_q;
  assign wr_z = done && zwe_q;

  assert_hold_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(res_hi) && $stable(res_lo) && $stable(res_z)));
  assert_flag_we_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_n || wr_z) |-> done);
  assert_zext_clears_n_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && zext_q) |-> !res_n);
  assert_done_in_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
endmodule

// File: tb/acc_xform_unit_test.sv
module acc_xform_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [15:0] req_hi = '0, req_lo = '0;
  logic req_ready, busy, done, res_n, res_z, wr_n, wr_z;
  logic [15:0] res_hi, res_lo;
  int total = 0, bad = 0, cycles = 0;

  always #5 clk = ~clk;

  acc_xform_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_hi(req_hi), .req_lo(req_lo), .busy(busy), .done(done),
    .res_hi(res_hi), .res_lo(res_lo), .res_n(res_n), .res_z(res_z),
    .wr_n(wr_n), .wr_z(wr_z)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      chk(1'b0, "watchdog", cycles, 0);
      finish_run();
    end
  end

  // Issue one operation, optionally pushing a distractor request while busy (R4).
  task automatic run_op(input logic [2:0] op, input logic [15:0] hi, input logic [15:0] lo,
                        input logic [15:0] ehi, input logic [15:0] elo,
                        input logic ewn, input logic ewz, input logic en, input logic ez,
                        input int lat, input string tag, input logic distract);
    int n = 0;
    @(negedge clk);
    chk(req_ready, {tag, " R1 ready"}, req_ready, 1);
    req_valid = 1'b1; req_op = op; req_hi = hi; req_lo = lo;
    @(negedge clk);
    if (distract) begin
      req_op = 3'd5; req_hi = 16'h1234; req_lo = 16'h0000;
    end else req_valid = 1'b0;
    forever begin
      n++;
      chk(busy && !req_ready, {tag, " R3 busy"}, {busy, req_ready}, 2'b10);
      if (done || n > 10) break;
      chk(!wr_n && !wr_z, {tag, " R11 idle we"}, {wr_n, wr_z}, 0);
      @(negedge clk);
    end
    chk(n == lat, {tag, " R2 latency"}, n, lat);
    chk(res_hi == ehi, {tag, " hi"}, res_hi, ehi);
    chk(res_lo == elo, {tag, " lo"}, res_lo, elo);
    chk(wr_n == ewn && wr_z == ewz, {tag, " R11 we"}, {wr_n, wr_z}, {ewn, ewz});
    if (ewn) chk(res_n == en, {tag, " N"}, res_n, en);
    if (ewz) chk(res_z == ez, {tag, " Z"}, res_z, ez);
    req_valid = 1'b0;
    @(negedge clk);
    chk(!busy && !done, {tag, " R3 idle after"}, {busy, done}, 0);
  endtask

  task automatic t_reset();
    chk(req_ready && !busy && !done && !wr_n && !wr_z, "R1 reset",
        {req_ready, busy, done, wr_n, wr_z}, 5'b10000);
  endtask

  task automatic t_illegal(input logic [2:0] op);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_hi = 16'hAAAA; req_lo = 16'h5555;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!busy && !done, "R12 illegal code", {busy, done}, 0);
    @(negedge clk);
    chk(!busy && !done, "R12 illegal code later", {busy, done}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    run_op(3'd0, 16'hBEEF, 16'h12F0, 16'hBEEF, 16'hF012, 0, 0, 0, 0, 3, "R5 bswap", 0);
    run_op(3'd1, 16'hCAFE, 16'h0001, 16'h0001, 16'hCAFE, 0, 0, 0, 0, 2, "R6 hxchg", 0);
    run_op(3'd2, 16'h7777, 16'h0080, 16'h7777, 16'hFF80, 1, 1, 1, 0, 1, "R7 sextb neg", 0);
    run_op(3'd2, 16'h7777, 16'hFF00, 16'h7777, 16'h0000, 1, 1, 0, 1, 1, "R7 sextb zero", 0);
    run_op(3'd3, 16'h0000, 16'h8001, 16'hFFFF, 16'h8001, 1, 1, 1, 0, 2, "R8 sextw neg", 0);
    run_op(3'd3, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 1, 1, 0, 1, 2, "R8 sextw zero", 0);
    run_op(3'd4, 16'h1111, 16'hFF80, 16'h1111, 16'h0080, 1, 1, 0, 0, 1, "R9 zextb", 0);
    run_op(3'd4, 16'h1111, 16'hAB00, 16'h1111, 16'h0000, 1, 1, 0, 1, 1, "R9 zextb zero", 0);
    run_op(3'd5, 16'hFFFF, 16'h8000, 16'h0000, 16'h8000, 1, 1, 0, 0, 1, "R10 zextw", 0);
    run_op(3'd5, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 1, 1, 0, 1, 1, "R10 zextw zero", 0);
    run_op(3'd0, 16'h0F0F, 16'h3456, 16'h0F0F, 16'h5634, 0, 0, 0, 0, 3, "R4 busy ignore", 1);
    t_illegal(3'd6);
    t_illegal(3'd7);
    finish_run();
  end
endmodule